// File: doc/BRIEF.md
# Temperature Event Comparator with Hysteresis

This block watches a stream of signed temperature samples and decides when a thermal event should be signalled. Each sample is a 13-bit two's-complement word at 1/16 °C per count and arrives with a one-cycle strobe. The block keeps the most recent sample and compares it every cycle against three limits: a high alarm, a low alarm and a critical limit. The two upper comparisons can use a selectable hysteresis. The compare results are visible as three trip flags.

The trip flags feed an event stage with two modes. In comparator mode the event follows the trip flags. In interrupt mode the event latches on each alarm crossing and software releases it with a clear pulse. A critical-only setting ignores the alarm window. A critical trip always forces the event and cannot be cleared. The event reaches an open-drain pad through an enable and a polarity choice. A shutdown input freezes the held sample, the trip flags and the event. Limit changes take effect on the next clock edge and do not wait for a new sample.

Top module: `temp_event_cmp`

## Requirements
- R1: One clock edge after a strobed sample, `trip_flags` shows the compare results. Bit 2 is set when the sample is at or above `lim_crit`. Bit 1 is set when the sample is strictly above `lim_high`. Bit 0 is set when the sample is strictly below `lim_low`. All values are signed 13-bit.
- R2: Hysteresis applies to bits 2 and 1 only. `cfg_hyst` codes 0, 1, 2 and 3 give H = 0, 24, 48 and 96 counts. Once set, bit 2 stays set while the temperature is at or above `lim_crit`−H. Once set, bit 1 stays set while the temperature is above `lim_high`−H. Bit 0 has no hysteresis.
- R3: The held temperature is compared every cycle. A change to any limit updates `trip_flags` and the event one edge later, without a new strobe.
- R4: In comparator mode (`cfg_int_mode`=0, `cfg_crit_only`=0), the event is asserted exactly when any trip flag is set.
- R5: In interrupt mode (`cfg_int_mode`=1, `cfg_crit_only`=0), any change of trip bit 1 or bit 0 latches the event. A `clr_event` pulse releases the latch. A crossing in the same cycle as a clear wins. The latch is dropped whenever the block is not in interrupt mode with critical-only off.
- R6: While trip bit 2 is set, the event is asserted in every mode, and `clr_event` has no effect on it.
- R7: With `cfg_crit_only`=1, only trip bit 2 can assert the event, in both modes.
- R8: `event_pull_low` is the pad pull-down. With `cfg_pol_high`=0 it is 1 only when the output is enabled and the event is asserted. With `cfg_pol_high`=1 it is 0 only when the output is enabled and the event is asserted. When the output is disabled it is 0 for active-low and 1 for active-high.
- R9: `event_status` is 1 when the event is asserted and `cfg_out_en`=1, whatever the polarity.
- R10: While `cfg_shutdown`=1, the held temperature, the trip flags and the event state do not change. Strobes, limit changes and clear pulses are ignored during that time.
- R11: Synchronous reset clears the held temperature, the trip flags and the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | 1 | Strobe marking a new temperature sample |
| samp_temp | input | 13 | Signed sample, 1/16 °C per count |
| lim_high | input | 13 | Upper alarm limit, same scale |
| lim_low | input | 13 | Lower alarm limit, same scale |
| lim_crit | input | 13 | Critical limit, same scale |
| cfg_hyst | input | 2 | Hysteresis code for the upper trip points |
| cfg_shutdown | input | 1 | Freeze temperature, trips and event |
| cfg_int_mode | input | 1 | 1 = interrupt (latched) mode, 0 = comparator mode |
| cfg_crit_only | input | 1 | Only the critical trip raises the event |
| cfg_pol_high | input | 1 | 1 = active-high pad, 0 = active-low pad |
| cfg_out_en | input | 1 | Event output enable |
| clr_event | input | 1 | Pulse that releases a latched interrupt event |
| trip_flags | output | 3 | {critical, above high, below low} |
| event_status | output | 1 | Polarity-independent asserted event |
| event_pull_low | output | 1 | Open-drain pad pull-down enable |

## Verification
The assertions check four relations on every cycle. A set critical flag always goes with an asserted event. Comparator mode and critical-only mode tie the event to the trip flags. Shutdown holds the trip flags and the event steady. The pad follows the event for an enabled active-low output. Hysteresis release points, the interrupt latch under clears, crossings and mode changes, immediate re-evaluation after a limit write, and the fact that strobes are dropped during shutdown can only be shown by the bench's directed sequences and its random run against a model.

// File: rtl/tevt_pkg.sv
package tevt_pkg;

    typedef struct packed {
        logic crit;
        logic high;
        logic low;
    } trip_t;

    typedef struct packed {
        logic       shutdown;
        logic       int_mode;
        logic       crit_only;
        logic       pol_high;
        logic       out_en;
        logic [1:0] hyst;
    } evt_cfg_t;

    // Hysteresis amount in sample counts: 0, 1.5, 3, 6 degrees at 2^-fb scale.
    function automatic int unsigned hyst_counts(input logic [1:0] code, input int unsigned fb);
        int unsigned base;
        base = (32'd3 << fb) >> 1;
        case (code)
            2'd0:    return 0;
            2'd1:    return base;
            2'd2:    return base << 1;
            default: return base << 2;
        endcase
    endfunction

endpackage

// File: rtl/tevt_trip_eval.sv
module tevt_trip_eval
    import tevt_pkg::*;
#(
    parameter int TW = 13,
    parameter int FB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          samp_valid,
    input  logic [TW-1:0] samp_temp,
    input  logic [TW-1:0] lim_high,
    input  logic [TW-1:0] lim_low,
    input  logic [TW-1:0] lim_crit,
    input  logic [1:0]    hyst_code,
    output trip_t         trip_d,
    output trip_t         trip_q
);
    localparam int EW = TW + 1;
    localparam int NUP = 2;

    logic [TW-1:0]        temp_q;
    logic [TW-1:0]        cur_temp;
    logic signed [EW-1:0] t_ext;
    logic signed [EW-1:0] lo_ext;
    logic signed [EW-1:0] hyst_amt;
    logic [NUP-1:0]       up_prev;
    logic [NUP-1:0]       up_next;

    assign cur_temp = samp_valid ? samp_temp : temp_q;
    assign t_ext    = $signed({cur_temp[TW-1], cur_temp});
    assign lo_ext   = $signed({lim_low[TW-1], lim_low});
    assign hyst_amt = $signed(EW'(hyst_counts(hyst_code, FB)));
    assign up_prev  = {trip_q.high, trip_q.crit};

    // Index 0: critical (inclusive compare), index 1: high alarm (strict compare)
    for (genvar g = 0; g < NUP; g++) begin : g_upper
        localparam bit INCL = (g == 0);
        logic [TW-1:0]        lim_raw;
        logic signed [EW-1:0] lim_ext;
        logic signed [EW-1:0] rel_ext;
        logic                 set_hit;
        logic                 keep_hit;

        assign lim_raw  = (g == 0) ? lim_crit : lim_high;
        assign lim_ext  = $signed({lim_raw[TW-1], lim_raw});
        assign rel_ext  = lim_ext - hyst_amt;
        assign set_hit  = INCL ? (t_ext >= lim_ext) : (t_ext > lim_ext);
        assign keep_hit = INCL ? (t_ext >= rel_ext) : (t_ext > rel_ext);
        assign up_next[g] = set_hit | (up_prev[g] & keep_hit);
    end

    always_comb begin
        trip_d.crit = up_next[0];
        trip_d.high = up_next[1];
        trip_d.low  = (t_ext < lo_ext);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= '0;
            trip_q <= '0;
        end else if (!hold) begin
            if (samp_valid) temp_q <= samp_temp;
            trip_q <= trip_d;
        end
    end

endmodule

// File: rtl/tevt_event_ctrl.sv
module tevt_event_ctrl
    import tevt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  int_mode,
    input  logic  crit_only,
    input  logic  clr,
    input  trip_t trip_d,
    input  trip_t trip_q,
    output logic  evt_q
);
    logic latch_q;
    logic latch_d;
    logic alarm_moved;
    logic evt_d;

    assign alarm_moved = (trip_d.high != trip_q.high) | (trip_d.low != trip_q.low);

    always_comb begin
        latch_d = latch_q;
        if (!int_mode || crit_only) begin
            latch_d = 1'b0;
        end else if (alarm_moved) begin
            latch_d = 1'b1;
        end else if (clr && !trip_d.crit) begin
            latch_d = 1'b0;
        end
    end

    always_comb begin
        if (crit_only)     evt_d = trip_d.crit;
        else if (int_mode) evt_d = trip_d.crit | latch_d;
        else               evt_d = trip_d.crit | trip_d.high | trip_d.low;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            evt_q   <= 1'b0;
        end else if (!hold) begin
            latch_q <= latch_d;
            evt_q   <= evt_d;
        end
    end

endmodule

// File: rtl/tevt_pad_drv.sv
module tevt_pad_drv (
    input  logic evt_q,
    input  logic out_en,
    input  logic pol_high,
    output logic status,
    output logic pull_low
);
    logic active;

    assign active   = evt_q & out_en;
    assign status   = active;
    assign pull_low = pol_high ? ~active : active;

endmodule

// File: rtl/temp_event_cmp.sv
module temp_event_cmp
    import tevt_pkg::*;
#(
    parameter int TEMP_W = 13,
    parameter int FRAC_B = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_valid,
    input  logic [TEMP_W-1:0] samp_temp,
    input  logic [TEMP_W-1:0] lim_high,
    input  logic [TEMP_W-1:0] lim_low,
    input  logic [TEMP_W-1:0] lim_crit,
    input  logic [1:0]        cfg_hyst,
    input  logic              cfg_shutdown,
    input  logic              cfg_int_mode,
    input  logic              cfg_crit_only,
    input  logic              cfg_pol_high,
    input  logic              cfg_out_en,
    input  logic              clr_event,
    output logic [2:0]        trip_flags,
    output logic              event_status,
    output logic              event_pull_low
);
    evt_cfg_t cfg;
    trip_t    trip_d;
    trip_t    trip_q;
    logic     evt_q;

    assign cfg = '{shutdown:  cfg_shutdown,
                   int_mode:  cfg_int_mode,
                   crit_only: cfg_crit_only,
                   pol_high:  cfg_pol_high,
                   out_en:    cfg_out_en,
                   hyst:      cfg_hyst};

    tevt_trip_eval #(.TW(TEMP_W), .FB(FRAC_B)) u_trip (
        .clk        (clk),
        .rst        (rst),
        .hold       (cfg.shutdown),
        .samp_valid (samp_valid),
        .samp_temp  (samp_temp),
        .lim_high   (lim_high),
        .lim_low    (lim_low),
        .lim_crit   (lim_crit),
        .hyst_code  (cfg.hyst),
        .trip_d     (trip_d),
        .trip_q     (trip_q)
    );

    tevt_event_ctrl u_evt (
        .clk       (clk),
        .rst       (rst),
        .hold      (cfg.shutdown),
        .int_mode  (cfg.int_mode),
        .crit_only (cfg.crit_only),
        .clr       (clr_event),
        .trip_d    (trip_d),
        .trip_q    (trip_q),
        .evt_q     (evt_q)
    );

    tevt_pad_drv u_pad (
        .evt_q    (evt_q),
        .out_en   (cfg.out_en),
        .pol_high (cfg.pol_high),
        .status   (event_status),
        .pull_low (event_pull_low)
    );

    assign trip_flags = trip_q;

endmodule

// File: rtl/tevt_checker.sv
module tevt_checker (
    input logic       clk,
    input logic       rst,
    input logic       shdn,
    input logic       int_mode,
    input logic       crit_only,
    input logic       out_en,
    input logic       pol_high,
    input logic [2:0] trips,
    input logic       evt_q,
    input logic       pad
);

    // R6: a critical trip always carries an asserted event
    assert_crit_forces_event_R6: assert property (@(posedge clk) disable iff (rst)
        trips[2] |-> evt_q);

    // R10: shutdown holds trips and event
    assert_shutdown_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        shdn |=> ($stable(trips) && $stable(evt_q)));

    // R4: comparator mode follows the trip flags
    assert_comparator_follow_R4: assert property (@(posedge clk) disable iff (rst)
        $past(!int_mode && !crit_only && !shdn) |-> (evt_q == (|trips)));

    // R7: critical-only mode follows the critical flag
    assert_crit_only_R7: assert property (@(posedge clk) disable iff (rst)
        $past(crit_only && !shdn) |-> (evt_q == trips[2]));

    // R8: enabled active-low pad pulls down exactly while the event is asserted
    assert_pad_active_low_R8: assert property (@(posedge clk) disable iff (rst)
        (out_en && !pol_high) |-> (pad == evt_q));

endmodule

bind temp_event_cmp tevt_checker u_tevt_checker (
    .clk       (clk),
    .rst       (rst),
    .shdn      (cfg_shutdown),
    .int_mode  (cfg_int_mode),
    .crit_only (cfg_crit_only),
    .out_en    (cfg_out_en),
    .pol_high  (cfg_pol_high),
    .trips     (trip_flags),
    .evt_q     (evt_q),
    .pad       (event_pull_low)
);

// File: tb/temp_event_cmp_tb_top.sv
`timescale 1ns/1ps
module temp_event_cmp_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        samp_valid;
    logic [12:0] samp_temp;
    logic [12:0] lim_high;
    logic [12:0] lim_low;
    logic [12:0] lim_crit;
    logic [1:0]  cfg_hyst;
    logic        cfg_shutdown;
    logic        cfg_int_mode;
    logic        cfg_crit_only;
    logic        cfg_pol_high;
    logic        cfg_out_en;
    logic        clr_event;
    logic [2:0]  trip_flags;
    logic        event_status;
    logic        event_pull_low;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model state
    int       m_temp;
    bit [2:0] m_trip;
    bit       m_latch;
    bit       m_evt;

    always #2.5 clk = ~clk;

    temp_event_cmp dut_i (
        .clk            (clk),
        .rst            (rst),
        .samp_valid     (samp_valid),
        .samp_temp      (samp_temp),
        .lim_high       (lim_high),
        .lim_low        (lim_low),
        .lim_crit       (lim_crit),
        .cfg_hyst       (cfg_hyst),
        .cfg_shutdown   (cfg_shutdown),
        .cfg_int_mode   (cfg_int_mode),
        .cfg_crit_only  (cfg_crit_only),
        .cfg_pol_high   (cfg_pol_high),
        .cfg_out_en     (cfg_out_en),
        .clr_event      (clr_event),
        .trip_flags     (trip_flags),
        .event_status   (event_status),
        .event_pull_low (event_pull_low)
    );

    function automatic int sx(input logic [12:0] v);
        return int'($signed(v));
    endfunction

    function automatic int hyst_of(input logic [1:0] c);
        case (c)
            2'd0: return 0;
            2'd1: return 24;
            2'd2: return 48;
            default: return 96;
        endcase
    endfunction

    function automatic bit pad_of(input bit ev, input bit en, input bit pol);
        if (!en) return pol;
        return pol ? !ev : ev;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model by one clock using the inputs now applied.
    task automatic model_step();
        int  t, h, c, hi, lo;
        bit  nc, nh, nl, moved, nlatch;
        if (rst) begin
            m_temp = 0; m_trip = 3'b000; m_latch = 1'b0; m_evt = 1'b0;
            return;
        end
        if (cfg_shutdown) return;
        t  = samp_valid ? sx(samp_temp) : m_temp;
        h  = hyst_of(cfg_hyst);
        c  = sx(lim_crit);
        hi = sx(lim_high);
        lo = sx(lim_low);
        nc = (t >= c) || (m_trip[2] && t >= c - h);
        nh = (t > hi) || (m_trip[1] && t > hi - h);
        nl = (t < lo);
        moved = (nh != m_trip[1]) || (nl != m_trip[0]);
        nlatch = m_latch;
        if (!cfg_int_mode || cfg_crit_only) nlatch = 1'b0;
        else if (moved) nlatch = 1'b1;
        else if (clr_event && !nc) nlatch = 1'b0;
        if (cfg_crit_only) m_evt = nc;
        else if (cfg_int_mode) m_evt = nc | nlatch;
        else m_evt = nc | nh | nl;
        m_latch = nlatch;
        m_trip  = {nc, nh, nl};
        m_temp  = t;
    endtask

    // One clock: update model at the edge, compare at the falling edge.
    task automatic tick();
        bit ev_en;
        @(posedge clk);
        model_step();
        @(negedge clk);
        ev_en = m_evt & cfg_out_en;
        check(trip_flags == m_trip, "R1 R2 trip flags vs model", trip_flags, m_trip);
        check(event_status == ev_en, "R9 status vs model", event_status, ev_en);
        check(event_pull_low == pad_of(m_evt, cfg_out_en, cfg_pol_high),
              "R8 pad vs model", event_pull_low, pad_of(m_evt, cfg_out_en, cfg_pol_high));
    endtask

    task automatic sample(input int v);
        samp_temp  = 13'(v);
        samp_valid = 1'b1;
        tick();
        samp_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; samp_valid = 1'b0; samp_temp = '0;
        lim_high = 13'd400; lim_low = 13'd0; lim_crit = 13'd800;
        cfg_hyst = 2'd1; cfg_shutdown = 1'b0; cfg_int_mode = 1'b0;
        cfg_crit_only = 1'b0; cfg_pol_high = 1'b0; cfg_out_en = 1'b1;
        clr_event = 1'b0;
        m_temp = 0; m_trip = '0; m_latch = 1'b0; m_evt = 1'b0;
        repeat (3) tick();
        // R11: reset state
        check(trip_flags == 3'b000, "R11 reset trips", trip_flags, 0);
        check(event_status == 1'b0, "R11 reset status", event_status, 0);
        check(event_pull_low == 1'b0, "R11 reset pad", event_pull_low, 0);
        rst = 1'b0;
        tick();

        // R1/R4: above high
        sample(401);
        check(trip_flags == 3'b010, "R1 above high", trip_flags, 3'b010);
        check(event_status == 1'b1, "R4 comparator asserts", event_status, 1);
        check(event_pull_low == 1'b1, "R8 active-low pulls", event_pull_low, 1);
        // R2: hysteresis 24 counts on the high point
        sample(400);
        check(trip_flags == 3'b010, "R2 held at limit", trip_flags, 3'b010);
        sample(377);
        check(trip_flags == 3'b010, "R2 held above release", trip_flags, 3'b010);
        sample(376);
        check(trip_flags == 3'b000, "R2 released at limit minus hyst", trip_flags, 0);
        check(event_status == 1'b0, "R4 comparator deasserts", event_status, 0);
        // R1: below low, no hysteresis
        sample(-1);
        check(trip_flags == 3'b001, "R1 below low", trip_flags, 3'b001);
        // R1: critical at equality
        sample(800);
        check(trip_flags == 3'b110, "R1 critical inclusive", trip_flags, 3'b110);
        // R6: clear ignored while critical
        cfg_int_mode = 1'b1; clr_event = 1'b1;
        tick();
        clr_event = 1'b0;
        check(event_status == 1'b1, "R6 clear ignored in critical", event_status, 1);
        sample(799);
        check(trip_flags == 3'b110, "R2 critical hysteresis hold", trip_flags, 3'b110);
        sample(700);
        // R5: crossing back inside latches, clear releases
        sample(200);
        check(event_status == 1'b1, "R5 crossing latches", event_status, 1);
        tick();
        check(event_status == 1'b1, "R5 latch holds", event_status, 1);
        clr_event = 1'b1; tick(); clr_event = 1'b0;
        check(event_status == 1'b0, "R5 clear releases", event_status, 0);
        sample(500);
        check(event_status == 1'b1, "R5 new crossing", event_status, 1);
        // R7: critical-only
        cfg_int_mode = 1'b0; cfg_crit_only = 1'b1;
        tick();
        check(event_status == 1'b0, "R7 alarm ignored", event_status, 0);
        sample(900);
        check(event_status == 1'b1, "R7 critical asserts", event_status, 1);
        sample(500);
        check(event_status == 1'b0, "R7 critical released", event_status, 0);
        // R3: limit change without sample
        cfg_crit_only = 1'b0;
        lim_high = 13'd600;
        tick();
        check(trip_flags == 3'b000, "R3 high limit raised", trip_flags, 0);
        lim_low = 13'd550;
        tick();
        check(trip_flags == 3'b001, "R3 low limit raised", trip_flags, 3'b001);
        // R10: shutdown freeze
        cfg_shutdown = 1'b1;
        tick();
        sample(1000);
        check(trip_flags == 3'b001, "R10 strobe ignored", trip_flags, 3'b001);
        lim_low = 13'd0;
        tick();
        check(trip_flags == 3'b001, "R10 limit ignored", trip_flags, 3'b001);
        check(event_status == 1'b1, "R10 event frozen", event_status, 1);
        cfg_shutdown = 1'b0;
        tick();
        check(trip_flags == 3'b000, "R10 held temperature kept", trip_flags, 0);
        // R8/R9: enable and polarity
        lim_low = 13'd550;
        tick();
        cfg_out_en = 1'b0; tick();
        check(event_pull_low == 1'b0, "R8 disabled active-low floats", event_pull_low, 0);
        check(event_status == 1'b0, "R9 disabled status", event_status, 0);
        cfg_pol_high = 1'b1; tick();
        check(event_pull_low == 1'b1, "R8 disabled active-high low", event_pull_low, 1);
        cfg_out_en = 1'b1; tick();
        check(event_pull_low == 1'b0, "R8 active-high asserted releases", event_pull_low, 0);
        check(event_status == 1'b1, "R9 status ignores polarity", event_status, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            samp_valid = (r < 50);
            samp_temp  = 13'($urandom_range(0, 1400) - 200);
            clr_event  = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 49) == 0) begin
                lim_high = 13'($urandom_range(0, 800));
                lim_low  = 13'($urandom_range(0, 600) - 200);
                lim_crit = 13'($urandom_range(300, 1100));
            end
            if ($urandom_range(0, 29) == 0) begin
                cfg_int_mode  = 1'($urandom_range(0, 1));
                cfg_crit_only = ($urandom_range(0, 3) == 0);
                cfg_hyst      = 2'($urandom_range(0, 3));
                cfg_pol_high  = 1'($urandom_range(0, 1));
                cfg_out_en    = ($urandom_range(0, 4) != 0);
            end
            if ($urandom_range(0, 39) == 0) cfg_shutdown = ~cfg_shutdown;
            tick();
        end
        samp_valid = 1'b0; clr_event = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule